// File: doc/BRIEF.md
# Single-Wire Bus Address-Command and Search Layer

This block is the addressing tier of a single-wire slave. It sits above a bit-slot engine. The engine reports three kinds of event, each as a one-cycle pulse: a bus reset with presence, a write slot carrying one received bit, and a read slot. In return, the engine takes one level from this block, which says whether the slave pulls the line low during the current read slot. A released line reads as 1. Because the line is open-drain, several slaves talking at once combine as a wired AND.

After every bus reset, the first eight write slots form an address-command byte. Depending on that opcode, the block does one of four things:
- streams its own 64-bit node address out through read slots;
- compares 64 address bits written by the master;
- selects itself at once;
- takes part in the bit-wise search, where each address bit uses three slots.

When addressing succeeds, the block raises `select_o` for the function-command layer. It holds that signal until the next bus reset. If a comparison or search fails, or the opcode is unknown, the block falls silent until the next reset.

Top module: `ow_rom_layer`

## Requirements
- R1: After `rst_n` is released, `select_o` and `drive_low_o` are 0. All write and read slots are ignored until the first `bus_reset_i` pulse.
- R2: A `bus_reset_i` pulse at any point aborts the current command and restarts opcode collection. On the next cycle `select_o` and `drive_low_o` are 0. A reset wins over a write or read slot reported in the same cycle.
- R3: The opcode is assembled from the first eight write slots after a reset, least-significant bit first.
- R4: Opcode 33h: the next 64 read slots carry `node_addr_i` bit 0 first, with `drive_low_o` high exactly when that bit is 0. After the 64th slot, `select_o` rises.
- R5: Opcode 55h: the next 64 write slots are compared with `node_addr_i`, bit 0 first. If all match, `select_o` is 1 in the cycle after the 64th slot.
- R6: Opcode 55h: a single mismatching bit leaves `select_o` at 0 and the line released on every read slot until the next reset.
- R7: Opcode CCh raises `select_o` in the cycle after the eighth opcode bit, with no address transfer.
- R8: Opcode F0h: each address bit, bit 0 first, takes three slots. In the first read slot `drive_low_o` equals the inverse of the bit. In the second read slot it equals the bit itself. The third slot is a write slot carrying the master's choice.
- R9: In a search, a choice that differs from the node's own bit drops the node out: no select, line released until reset. If all 64 choices match, `select_o` rises after the last one.
- R10: Any opcode other than 33h, 55h, CCh or F0h leaves `select_o` at 0 and the line released until the next reset.
- R11: While `select_o` is 1, `drive_low_o` is 0 and further slots leave `select_o` at 1 until a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse: bus reset/presence completed |
| rx_valid_i | input | 1 | One-cycle pulse: write slot received |
| rx_bit_i | input | 1 | Bit value of the write slot |
| rd_req_i | input | 1 | One-cycle pulse: read slot taking place |
| node_addr_i | input | 64 | This node's address (family, serial, CRC; bit 0 sent first) |
| drive_low_o | output | 1 | Pull the line low in the current read slot |
| select_o | output | 1 | Node is addressed; function layer may respond |

## Verification
The bus reset can coincide with a slot event, and the block must give the reset priority. The bench provokes this by raising `bus_reset_i` in the same cycle as a write slot. It does so both in the middle of a match and while the node is already selected. It then judges the result at the ports: `select_o` must be low on the following cycle, and a fresh skip opcode must still be collected from bit 0. Randomised addresses, mismatch positions and opcodes cover the other paths.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;
    localparam int CMD_W = 8;

    typedef enum logic [2:0] {
        ST_HALT,
        ST_CMD,
        ST_SEND,
        ST_MATCH,
        ST_SEARCH,
        ST_SEL
    } rom_st_e;

    typedef enum logic [1:0] {
        PH_TRUE,
        PH_COMP,
        PH_CHOICE
    } srch_ph_e;

    localparam logic [CMD_W-1:0] OP_READ   = 8'h33;
    localparam logic [CMD_W-1:0] OP_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] OP_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] OP_SEARCH = 8'hF0;
endpackage

// File: rtl/ow_rom_opdec.sv
module ow_rom_opdec
    import ow_rom_pkg::*;
(
    input  logic [CMD_W-1:0] op_i,
    output rom_st_e          next_o
);
    always_comb begin
        unique case (op_i)
            OP_READ:   next_o = ST_SEND;
            OP_MATCH:  next_o = ST_MATCH;
            OP_SKIP:   next_o = ST_SEL;
            OP_SEARCH: next_o = ST_SEARCH;
            default:   next_o = ST_HALT;
        endcase
    end
endmodule

// File: rtl/ow_addr_tap.sv
module ow_addr_tap #(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = $clog2(ADDR_W)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic              bit_o,
    output logic              last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_W - 1);

    assign bit_o  = addr_i[idx_i];
    assign last_o = (idx_i == LAST_IDX);
endmodule

// File: rtl/ow_rom_layer.sv
module ow_rom_layer
    import ow_rom_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset_i,
    input  logic              rx_valid_i,
    input  logic              rx_bit_i,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] node_addr_i,
    output logic              drive_low_o,
    output logic              select_o
);
    localparam int IDX_W = $clog2(ADDR_W);
    localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);

    typedef struct packed {
        rom_st_e          st;
        srch_ph_e         ph;
        logic [IDX_W-1:0] idx;
        logic [CMD_W-1:0] cmd;
    } ctx_t;

    ctx_t d, q;

    logic [CMD_W-1:0] cmd_next;
    rom_st_e          op_st;
    logic             abit;
    logic             alast;

    assign cmd_next = {rx_bit_i, q.cmd[CMD_W-1:1]};

    ow_rom_opdec u_dec (
        .op_i   (cmd_next),
        .next_o (op_st)
    );

    ow_addr_tap #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tap (
        .addr_i (node_addr_i),
        .idx_i  (q.idx),
        .bit_o  (abit),
        .last_o (alast)
    );

    always_comb begin
        d = q;
        if (bus_reset_i) begin
            d.st  = ST_CMD;
            d.ph  = PH_TRUE;
            d.idx = '0;
            d.cmd = '0;
        end else begin
            unique case (q.st)
                ST_CMD: begin
                    if (rx_valid_i) begin
                        d.cmd = cmd_next;
                        if (q.idx == CMD_LAST) begin
                            d.st  = op_st;
                            d.idx = '0;
                            d.ph  = PH_TRUE;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end
                end
                ST_SEND: begin
                    if (rd_req_i) begin
                        if (alast) d.st = ST_SEL;
                        else       d.idx = q.idx + 1'b1;
                    end
                end
                ST_MATCH: begin
                    if (rx_valid_i) begin
                        if (rx_bit_i != abit) d.st = ST_HALT;
                        else if (alast)       d.st = ST_SEL;
                        else                  d.idx = q.idx + 1'b1;
                    end
                end
                ST_SEARCH: begin
                    unique case (q.ph)
                        PH_TRUE:   if (rd_req_i) d.ph = PH_COMP;
                        PH_COMP:   if (rd_req_i) d.ph = PH_CHOICE;
                        default: begin
                            if (rx_valid_i) begin
                                if (rx_bit_i != abit) begin
                                    d.st = ST_HALT;
                                end else if (alast) begin
                                    d.st = ST_SEL;
                                end else begin
                                    d.idx = q.idx + 1'b1;
                                    d.ph  = PH_TRUE;
                                end
                            end
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_HALT;
            q.ph  <= PH_TRUE;
            q.idx <= '0;
            q.cmd <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        drive_low_o = 1'b0;
        if (q.st == ST_SEND) begin
            drive_low_o = ~abit;
        end else if (q.st == ST_SEARCH) begin
            if (q.ph == PH_TRUE)      drive_low_o = ~abit;
            else if (q.ph == PH_COMP) drive_low_o = abit;
        end
    end

    assign select_o = (q.st == ST_SEL);
endmodule

// File: rtl/ow_rom_layer_chk.sv
module ow_rom_layer_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_reset_i,
    input logic rx_valid_i,
    input logic rd_req_i,
    input logic drive_low_o,
    input logic select_o
);
    p_reset_drops_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> !select_o);

    p_reset_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_i |=> !drive_low_o);

    p_sel_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        select_o |-> !drive_low_o);

    p_sel_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (select_o && !bus_reset_i) |=> select_o);

    // R5, R7: selection only ever follows a slot event
    p_sel_on_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(select_o) |-> $past(rx_valid_i || rd_req_i));
endmodule

bind ow_rom_layer ow_rom_layer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset_i (bus_reset_i),
    .rx_valid_i  (rx_valid_i),
    .rd_req_i    (rd_req_i),
    .drive_low_o (drive_low_o),
    .select_o    (select_o)
);

// File: tb/tb_ow_rom_layer.sv
module tb_ow_rom_layer;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_reset_i = 1'b0;
    logic          rx_valid_i = 1'b0;
    logic          rx_bit_i = 1'b0;
    logic          rd_req_i = 1'b0;
    logic [AW-1:0] node_addr_i = '0;
    logic          drive_low_o;
    logic          select_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ow_rom_layer #(.ADDR_W(AW)) dut (.*);

    function automatic logic exp_bit(logic [AW-1:0] a, int i);
        return a[i];
    endfunction

    function automatic bit known_op(logic [7:0] op);
        return (op == 8'h33) || (op == 8'h55) || (op == 8'hCC) || (op == 8'hF0);
    endfunction

    task automatic chk(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_rst();
        bus_reset_i = 1'b1;
        @(negedge clk);
        bus_reset_i = 1'b0;
    endtask

    task automatic wr(logic b);
        rx_valid_i = 1'b1;
        rx_bit_i   = b;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic rd(output logic lvl);
        lvl = ~drive_low_o;
        rd_req_i = 1'b1;
        @(negedge clk);
        rd_req_i = 1'b0;
    endtask

    task automatic send_op(logic [7:0] op);
        for (int i = 0; i < 8; i++) wr(op[i]);
    endtask

    task automatic expect_silent(string req);
        logic lvl;
        for (int i = 0; i < 4; i++) begin
            rd(lvl);
            chk(lvl == 1'b1, req, AW'(lvl), AW'(1));
        end
        wr(1'b0);
        chk(select_o == 1'b0, req, AW'(select_o), AW'(0));
    endtask

    task automatic t_read(logic [AW-1:0] a);
        logic [AW-1:0] got;
        logic lvl;
        bus_rst();
        send_op(8'h33);
        for (int i = 0; i < AW; i++) begin
            chk(select_o == 1'b0, "R4 no early select", AW'(select_o), AW'(0));
            rd(lvl);
            got[i] = lvl;
        end
        chk(got == a, "R4 address stream", got, a);
        chk(select_o == 1'b1, "R4 select after stream", AW'(select_o), AW'(1));
        rd(lvl);
        chk(lvl == 1'b1, "R11 released while selected", AW'(lvl), AW'(1));
        wr(1'b1);
        chk(select_o == 1'b1, "R11 select held", AW'(select_o), AW'(1));
    endtask

    task automatic t_match(logic [AW-1:0] a, int flip);
        bus_rst();
        send_op(8'h55);
        for (int i = 0; i < AW; i++) wr(exp_bit(a, i) ^ (i == flip));
        if (flip < 0) begin
            chk(select_o == 1'b1, "R5 match selects", AW'(select_o), AW'(1));
        end else begin
            chk(select_o == 1'b0, "R6 mismatch no select", AW'(select_o), AW'(0));
            expect_silent("R6 silent after mismatch");
        end
    endtask

    task automatic t_search(logic [AW-1:0] a, int wrong);
        logic t, c;
        bus_rst();
        send_op(8'hF0);
        for (int i = 0; i < AW; i++) begin
            rd(t);
            rd(c);
            chk(t == exp_bit(a, i), "R8 true bit", AW'(t), AW'(exp_bit(a, i)));
            chk(c == ~exp_bit(a, i), "R8 complement bit", AW'(c), AW'(~exp_bit(a, i)));
            if (i == wrong) begin
                wr(~exp_bit(a, i));
                chk(select_o == 1'b0, "R9 dropout no select", AW'(select_o), AW'(0));
                expect_silent("R9 silent after dropout");
                return;
            end
            wr(exp_bit(a, i));
        end
        chk(select_o == 1'b1, "R9 search selects", AW'(select_o), AW'(1));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [AW-1:0] a;
        logic [7:0] op;
        logic lvl;
        void'($urandom(32'd1234));
        a = {$urandom(), $urandom()};
        node_addr_i = a;
        repeat (3) @(negedge clk);
        chk(select_o == 1'b0 && drive_low_o == 1'b0, "R1 reset state",
            AW'({select_o, drive_low_o}), AW'(0));
        rst_n = 1'b1;
        @(negedge clk);
        send_op(8'hCC);
        chk(select_o == 1'b0, "R1 ignore before bus reset", AW'(select_o), AW'(0));
        rd(lvl);
        chk(lvl == 1'b1, "R1 released before bus reset", AW'(lvl), AW'(1));

        // R3, R7: skip opcode, checked one bit short and complete
        bus_rst();
        for (int i = 0; i < 7; i++) wr(op_bit(8'hCC, i));
        chk(select_o == 1'b0, "R3 seven bits not enough", AW'(select_o), AW'(0));
        wr(1'b1);
        chk(select_o == 1'b1, "R7 skip selects", AW'(select_o), AW'(1));

        // R2: reset colliding with a write slot while selected
        bus_reset_i = 1'b1; rx_valid_i = 1'b1; rx_bit_i = 1'b0;
        @(negedge clk);
        bus_reset_i = 1'b0; rx_valid_i = 1'b0;
        chk(select_o == 1'b0, "R2 reset drops select", AW'(select_o), AW'(0));
        send_op(8'hCC);
        chk(select_o == 1'b1, "R2 opcode restarts at bit0", AW'(select_o), AW'(1));

        // R2: reset in the middle of a match, colliding with a slot
        bus_rst();
        send_op(8'h55);
        for (int i = 0; i < 20; i++) wr(exp_bit(a, i));
        bus_reset_i = 1'b1; rx_valid_i = 1'b1; rx_bit_i = 1'b1;
        @(negedge clk);
        bus_reset_i = 1'b0; rx_valid_i = 1'b0;
        send_op(8'hCC);
        chk(select_o == 1'b1, "R2 abort match then skip", AW'(select_o), AW'(1));

        // directed corners: mismatch at first and last bit, dropout at bit 0 and 63
        t_match(a, 0);
        t_match(a, AW - 1);
        t_search(a, 0);
        t_search(a, AW - 1);
        t_match(a, -1);

        for (int it = 0; it < 12; it++) begin
            a = {$urandom(), $urandom()};
            node_addr_i = a;
            t_read(a);
            t_match(a, ($urandom() % 2) ? -1 : int'($urandom() % AW));
            t_search(a, ($urandom() % 2) ? -1 : int'($urandom() % AW));
            do op = 8'($urandom()); while (known_op(op));
            bus_rst();
            send_op(op);
            chk(select_o == 1'b0, "R10 unknown opcode", AW'(select_o), AW'(0));
            expect_silent("R10 silent after unknown opcode");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    function automatic logic op_bit(logic [7:0] op, int i);
        return op[i];
    endfunction
endmodule